// File: doc/BRIEF.md
# Output Range Clamp

This block limits each colour component of a pixel stream to a legal range. Each component is 12 bits wide. It sits at the end of a display pipe, before the link encoder. A 3-bit format code picks the range. The code can select pass-through, a fixed limited (video) range for an 8, 10 or 12 bit-per-component output, or a lower and upper bound programmed separately for each of the red, green and blue channels. An enable input must also be high before any clamping takes place.

The configuration inputs are not used directly. They are copied into an active set on a frame-start strobe, so a change never lands in the middle of a frame. Until the first strobe, the active set holds its reset values: disabled, code 0, and programmable bounds of 0x010 and 0xFEF. The result is registered once. Each valid input pixel produces one valid output pixel one clock later.

Top module: `range_clamp`

## Requirements
- R1: During and right after reset, `outValid` is 0 and `outR`, `outG` and `outB` are 0.
- R2: If the active enable is 0, every component passes through unchanged, whatever the format code.
- R3: Format code 0 (full range) and the unused codes 4, 5 and 6 pass every component through unchanged, even with the enable high.
- R4: Codes 1 (8 bpc), 2 (10 bpc) and 3 (12 bpc) clamp every channel to the limited range 16..235, scaled to the output depth and left-aligned in 12 bits. For all three depths this comes to lower 0x100 and upper 0xEB0.
- R5: Code 7 clamps each channel to its own programmed bounds: red to `cfgLoR`..`cfgHiR`, green to `cfgLoG`..`cfgHiG`, blue to `cfgLoB`..`cfgHiB`.
- R6: When clamping is active, a component below the lower bound becomes the lower bound, and a component above the upper bound becomes the upper bound. A component within the bounds, including one equal to a bound, is unchanged. The lower comparison is made first, so with a lower bound above the upper bound, any input under the lower bound gives the lower bound.
- R7: `outValid` equals `pixValid` from one clock earlier, and the result belongs to the pixel of that earlier cycle. While `pixValid` is low, the output components keep their last values.
- R8: The enable, format code and bounds are sampled only on a clock edge where `frameStart` is high. A pixel accepted on that same edge still uses the previous configuration.
- R9: After reset and before the first `frameStart`, the block is in bypass, whatever is driven on the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Strobe that loads the configuration inputs into the active set |
| cfgEnable | input | 1 | Clamp enable |
| cfgFormat | input | 3 | Format code: 0 full, 1/2/3 limited 8/10/12 bpc, 7 programmable, 4-6 bypass |
| cfgLoR | input | 12 | Programmable lower bound, red |
| cfgHiR | input | 12 | Programmable upper bound, red |
| cfgLoG | input | 12 | Programmable lower bound, green |
| cfgHiG | input | 12 | Programmable upper bound, green |
| cfgLoB | input | 12 | Programmable lower bound, blue |
| cfgHiB | input | 12 | Programmable upper bound, blue |
| pixValid | input | 1 | Input pixel valid |
| pixR | input | 12 | Input red component |
| pixG | input | 12 | Input green component |
| pixB | input | 12 | Input blue component |
| outValid | output | 1 | Output pixel valid |
| outR | output | 12 | Output red component |
| outG | output | 12 | Output green component |
| outB | output | 12 | Output blue component |

## Verification
The in-range assertion assumes that, whenever clamping is active, the active lower bound does not exceed the upper bound. It is switched off for a channel whose bounds are inverted. The bypass and hold assertions assume nothing about the pixel values.

The stimulus changes the configuration only through `frameStart`, with no pixel in flight. The one exception is a single directed case that checks the R8 ordering on purpose. The inverted-bound case is run only as a directed check at the ports, so the property stays quiet there.

// File: rtl/rclamp_pkg.sv
package rclamp_pkg;

  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] FMT_FULL  = 3'd0;
  localparam logic [CODE_W-1:0] FMT_LIM8  = 3'd1;
  localparam logic [CODE_W-1:0] FMT_LIM10 = 3'd2;
  localparam logic [CODE_W-1:0] FMT_LIM12 = 3'd3;
  localparam logic [CODE_W-1:0] FMT_PROG  = 3'd7;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clampOn;
    logic useProg;
  } clampCtl_t;

  // Scale an 8-bit video level to 'depth' bits, then left-align it in 'width' bits
  function automatic int unsigned scaleLevel(input int unsigned level8,
                                             input int unsigned depth,
                                             input int unsigned width);
    return (level8 << (depth - 8)) << (width - depth);
  endfunction

endpackage

// File: rtl/rclamp_ctrl.sv
module rclamp_ctrl
  import rclamp_pkg::*;
#(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned NUM_CH = 3,
  parameter logic [PIX_W-1:0] LO_DEF = 12'h010,
  parameter logic [PIX_W-1:0] HI_DEF = 12'hFEF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    cfgEnable,
  input  logic [CODE_W-1:0]       cfgFormat,
  input  logic [PIX_W-1:0]        cfgLo [NUM_CH],
  input  logic [PIX_W-1:0]        cfgHi [NUM_CH],
  output clampCtl_t               ctl,
  output logic [PIX_W-1:0]        bndLo [NUM_CH],
  output logic [PIX_W-1:0]        bndHi [NUM_CH]
);

  localparam int unsigned VID_LO = 16;
  localparam int unsigned VID_HI = 235;

  localparam logic [PIX_W-1:0] FIX_LO8  = PIX_W'(scaleLevel(VID_LO, 8,  PIX_W));
  localparam logic [PIX_W-1:0] FIX_HI8  = PIX_W'(scaleLevel(VID_HI, 8,  PIX_W));
  localparam logic [PIX_W-1:0] FIX_LO10 = PIX_W'(scaleLevel(VID_LO, 10, PIX_W));
  localparam logic [PIX_W-1:0] FIX_HI10 = PIX_W'(scaleLevel(VID_HI, 10, PIX_W));
  localparam logic [PIX_W-1:0] FIX_LO12 = PIX_W'(scaleLevel(VID_LO, 12, PIX_W));
  localparam logic [PIX_W-1:0] FIX_HI12 = PIX_W'(scaleLevel(VID_HI, 12, PIX_W));

  // Active (frame-aligned) configuration
  logic                actEn;
  logic [CODE_W-1:0]   actFmt;
  logic [PIX_W-1:0]    actLo [NUM_CH];
  logic [PIX_W-1:0]    actHi [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEn  <= 1'b0;
      actFmt <= FMT_FULL;
      for (int c = 0; c < NUM_CH; c++) begin
        actLo[c] <= LO_DEF;
        actHi[c] <= HI_DEF;
      end
    end else if (frameStart) begin
      actEn  <= cfgEnable;
      actFmt <= cfgFormat;
      for (int c = 0; c < NUM_CH; c++) begin
        actLo[c] <= cfgLo[c];
        actHi[c] <= cfgHi[c];
      end
    end
  end

  // Format decode
  logic             isFixed;
  logic             isProg;
  logic [PIX_W-1:0] fixLo;
  logic [PIX_W-1:0] fixHi;

  always_comb begin
    isFixed = 1'b0;
    fixLo   = FIX_LO12;
    fixHi   = FIX_HI12;
    case (actFmt)
      FMT_LIM8:  begin isFixed = 1'b1; fixLo = FIX_LO8;  fixHi = FIX_HI8;  end
      FMT_LIM10: begin isFixed = 1'b1; fixLo = FIX_LO10; fixHi = FIX_HI10; end
      FMT_LIM12: begin isFixed = 1'b1; fixLo = FIX_LO12; fixHi = FIX_HI12; end
      default:   ;
    endcase
  end

  assign isProg      = (actFmt == FMT_PROG);
  assign ctl.clampOn = actEn & (isFixed | isProg);
  assign ctl.useProg = actEn & isProg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bnd
    assign bndLo[c] = ctl.useProg ? actLo[c] : fixLo;
    assign bndHi[c] = ctl.useProg ? actHi[c] : fixHi;
  end

  // The configuration seen by the datapath moves only on a frame strobe
  AST_CTL_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(ctl)) else $error("ctl changed without frameStart"); // R8

endmodule

// File: rtl/rclamp_dp.sv
module rclamp_dp
  import rclamp_pkg::*;
#(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned NUM_CH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  clampCtl_t        ctl,
  input  logic [PIX_W-1:0] bndLo [NUM_CH],
  input  logic [PIX_W-1:0] bndHi [NUM_CH],
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixIn  [NUM_CH],
  output logic             outValid,
  output logic [PIX_W-1:0] pixOut [NUM_CH]
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= pixValid;
  end

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid) else $error("valid lost"); // R7
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid) else $error("spurious valid"); // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PIX_W-1:0] nextVal;

    always_comb begin
      if (!ctl.clampOn)              nextVal = pixIn[c];
      else if (pixIn[c] < bndLo[c])  nextVal = bndLo[c];
      else if (pixIn[c] > bndHi[c])  nextVal = bndHi[c];
      else                           nextVal = pixIn[c];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         pixOut[c] <= '0;
      else if (pixValid) pixOut[c] <= nextVal;
    end

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      (pixValid && ctl.clampOn && (bndLo[c] <= bndHi[c])) |=>
        ((pixOut[c] >= $past(bndLo[c])) && (pixOut[c] <= $past(bndHi[c]))))
      else $error("component out of range"); // R6
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
      (pixValid && !ctl.clampOn) |=> (pixOut[c] == $past(pixIn[c])))
      else $error("bypass altered data"); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !pixValid |=> $stable(pixOut[c])) else $error("output moved without valid"); // R7
  end

endmodule

// File: rtl/range_clamp.sv
module range_clamp
  import rclamp_pkg::*;
#(
  parameter int unsigned PIX_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              cfgEnable,
  input  logic [2:0]        cfgFormat,
  input  logic [PIX_W-1:0]  cfgLoR,
  input  logic [PIX_W-1:0]  cfgHiR,
  input  logic [PIX_W-1:0]  cfgLoG,
  input  logic [PIX_W-1:0]  cfgHiG,
  input  logic [PIX_W-1:0]  cfgLoB,
  input  logic [PIX_W-1:0]  cfgHiB,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixR,
  input  logic [PIX_W-1:0]  pixG,
  input  logic [PIX_W-1:0]  pixB,
  output logic              outValid,
  output logic [PIX_W-1:0]  outR,
  output logic [PIX_W-1:0]  outG,
  output logic [PIX_W-1:0]  outB
);

  localparam int unsigned NUM_CH = 3;

  clampCtl_t        ctl;
  logic [PIX_W-1:0] cfgLo  [NUM_CH];
  logic [PIX_W-1:0] cfgHi  [NUM_CH];
  logic [PIX_W-1:0] bndLo  [NUM_CH];
  logic [PIX_W-1:0] bndHi  [NUM_CH];
  logic [PIX_W-1:0] pixIn  [NUM_CH];
  logic [PIX_W-1:0] pixOut [NUM_CH];

  assign cfgLo[0] = cfgLoR;  assign cfgHi[0] = cfgHiR;
  assign cfgLo[1] = cfgLoG;  assign cfgHi[1] = cfgHiG;
  assign cfgLo[2] = cfgLoB;  assign cfgHi[2] = cfgHiB;
  assign pixIn[0] = pixR;
  assign pixIn[1] = pixG;
  assign pixIn[2] = pixB;
  assign outR = pixOut[0];
  assign outG = pixOut[1];
  assign outB = pixOut[2];

  rclamp_ctrl #(.PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .cfgEnable(cfgEnable), .cfgFormat(cfgFormat),
    .cfgLo(cfgLo), .cfgHi(cfgHi),
    .ctl(ctl), .bndLo(bndLo), .bndHi(bndHi)
  );

  rclamp_dp #(.PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .bndLo(bndLo), .bndHi(bndHi),
    .pixValid(pixValid), .pixIn(pixIn),
    .outValid(outValid), .pixOut(pixOut)
  );

endmodule

// File: tb/range_clamp_tb.sv
module range_clamp_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [2:0]  cfgFormat = 3'd0;
  logic [11:0] cfgLoR = 12'h200, cfgHiR = 12'hC00;
  logic [11:0] cfgLoG = 12'h050, cfgHiG = 12'hF00;
  logic [11:0] cfgLoB = 12'h300, cfgHiB = 12'h400;
  logic        pixValid = 1'b0;
  logic [11:0] pixR = '0, pixG = '0, pixB = '0;
  logic        outValid;
  logic [11:0] outR, outG, outB;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  range_clamp u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .cfgEnable(cfgEnable), .cfgFormat(cfgFormat),
    .cfgLoR(cfgLoR), .cfgHiR(cfgHiR), .cfgLoG(cfgLoG), .cfgHiG(cfgHiG),
    .cfgLoB(cfgLoB), .cfgHiB(cfgHiB),
    .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  // {en, fmt, inR, inG, inB, expR, expG, expB}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 3'd0, 12'h000, 12'hFFF, 12'h800, 12'h000, 12'hFFF, 12'h800},  // R3
    {1'b0, 3'd1, 12'h000, 12'hFFF, 12'h050, 12'h000, 12'hFFF, 12'h050},  // R2
    {1'b1, 3'd1, 12'h000, 12'hFFF, 12'h800, 12'h100, 12'hEB0, 12'h800},  // R4
    {1'b1, 3'd2, 12'h0FF, 12'hEB1, 12'h100, 12'h100, 12'hEB0, 12'h100},  // R4
    {1'b1, 3'd3, 12'h100, 12'hEB0, 12'h010, 12'h100, 12'hEB0, 12'h100},  // R4
    {1'b1, 3'd4, 12'h000, 12'hFFF, 12'h001, 12'h000, 12'hFFF, 12'h001},  // R3
    {1'b1, 3'd5, 12'h00F, 12'hFF0, 12'hEB1, 12'h00F, 12'hFF0, 12'hEB1},  // R3
    {1'b1, 3'd6, 12'h0FF, 12'hFFF, 12'h000, 12'h0FF, 12'hFFF, 12'h000},  // R3
    {1'b1, 3'd7, 12'h100, 12'h010, 12'h500, 12'h200, 12'h050, 12'h400},  // R5
    {1'b1, 3'd7, 12'hFFF, 12'hF01, 12'h350, 12'hC00, 12'hF00, 12'h350},  // R5
    {1'b1, 3'd7, 12'h200, 12'hF00, 12'h300, 12'h200, 12'hF00, 12'h300},  // R6
    {1'b0, 3'd7, 12'h000, 12'hFFF, 12'h000, 12'h000, 12'hFFF, 12'h000}   // R2
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic chkRgb(input string tag, input logic [11:0] er, eg, eb);
    chk({tag, " R"}, outR, er);
    chk({tag, " G"}, outG, eg);
    chk({tag, " B"}, outB, eb);
  endtask

  task automatic loadCfg(input logic en, input logic [2:0] fmt);
    @(negedge clk);
    cfgEnable  = en;
    cfgFormat  = fmt;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // Drive one pixel at a falling edge, sample the result one rising edge later
  task automatic pushPix(input logic [11:0] r, g, b);
    pixR = r; pixG = g; pixB = b; pixValid = 1'b1;
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    pixValid = 1'b1; pixR = 12'hABC; pixG = 12'h123; pixB = 12'hFFF;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {11'd0, outValid}, 12'd0);
    chkRgb("R1 data in reset", 12'h000, 12'h000, 12'h000);
    pixValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {11'd0, outValid}, 12'd0);
    chkRgb("R1 data after reset", 12'h000, 12'h000, 12'h000);

    // R9: config inputs driven but never loaded -> bypass
    cfgEnable = 1'b1; cfgFormat = 3'd1;
    @(negedge clk);
    pushPix(12'h000, 12'hFFF, 12'h020);
    chk("R7 valid one cycle later", {11'd0, outValid}, 12'd1);
    chkRgb("R9 bypass before first frameStart", 12'h000, 12'hFFF, 12'h020);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      loadCfg(VEC[i][75], VEC[i][74:72]);
      pushPix(VEC[i][71:60], VEC[i][59:48], VEC[i][47:36]);
      chkRgb($sformatf("vector %0d (R2/R3/R4/R5/R6)", i),
             VEC[i][35:24], VEC[i][23:12], VEC[i][11:0]);
    end

    // R7: hold while no valid
    @(negedge clk);
    chk("R7 valid drops", {11'd0, outValid}, 12'd0);
    pixR = 12'h111; pixG = 12'h222; pixB = 12'h333;
    @(negedge clk);
    chkRgb("R7 hold without valid", 12'h000, 12'hFFF, 12'h000);

    // R6: exact bounds unchanged (programmable)
    loadCfg(1'b1, 3'd7);
    pushPix(12'hC00, 12'h050, 12'h400);
    chkRgb("R6 equal to bound", 12'hC00, 12'h050, 12'h400);

    // R6: inverted bounds on red, lower comparison first
    cfgLoR = 12'h800; cfgHiR = 12'h400;
    loadCfg(1'b1, 3'd7);
    pushPix(12'h600, 12'h000, 12'hFFF);
    chkRgb("R6 inverted bounds low side", 12'h800, 12'h050, 12'h400);
    pushPix(12'h900, 12'h060, 12'h3FF);
    chkRgb("R6 inverted bounds high side", 12'h400, 12'h060, 12'h3FF);
    cfgLoR = 12'h200; cfgHiR = 12'hC00;

    // R8: pixel in the frameStart cycle uses the old config (bypass)
    loadCfg(1'b0, 3'd0);
    @(negedge clk);
    cfgEnable = 1'b1; cfgFormat = 3'd1; frameStart = 1'b1;
    pixR = 12'h000; pixG = 12'hFFF; pixB = 12'h005; pixValid = 1'b1;
    @(negedge clk);
    frameStart = 1'b0; pixValid = 1'b0;
    chkRgb("R8 same-cycle pixel uses old config", 12'h000, 12'hFFF, 12'h005);
    pushPix(12'h000, 12'hFFF, 12'h005);
    chkRgb("R8 next pixel uses new config", 12'h100, 12'hEB0, 12'h100);

    // R8: input change without frameStart is not applied
    cfgEnable = 1'b0; cfgFormat = 3'd0;
    @(negedge clk);
    pushPix(12'hFFF, 12'h000, 12'h800);
    chkRgb("R8 config ignored without frameStart", 12'hEB0, 12'h100, 12'h800);

    finishRun();
  end

endmodule